// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block holds recently used page-table entries and turns a 32-bit virtual address into a 30-bit physical address for 4 KB pages. Every entry is tagged with an address-space number. Translations that belong to different processes can therefore stay resident at the same time, and a context switch does not need a flush. Each entry also carries a write-permission bit. A write to a page that does not allow writes is reported as a protection fault, even though the page is present, and that access produces no physical address.

The tag compare across all entries is combinational. The result of a request is registered and appears one cycle after the request. On a miss, the block raises a refill request. An external walker then loads the entry through the fill port, and the access is retried. The fill victim is the lowest-numbered invalid entry when one exists. Otherwise a tree pseudo-LRU, updated by fills and hits, picks the victim. One input clears every valid bit in a single cycle. Each entry has a reference bit that is set on a hit and a modify bit that is set on a permitted write hit. The first permitted write to a clean page is reported on an output, so that the walker can mark the page dirty in memory.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault`, `rsp_dirty_set` are 0 and `rsp_pa` is 0, and the first lookup misses.
- R2: A request whose address bits [31:12] and address-space number match a valid entry gives `rsp_valid`=1 and `rsp_hit`=1 on the cycle after the request. In that response `rsp_pa` = {entry physical page, `req_va`[11:0]}.
- R3: A request that matches no valid entry gives `rsp_miss`=1 on the next cycle, with `rsp_hit`=0, `rsp_fault`=0 and `rsp_pa`=0.
- R4: An entry whose page matches but whose address-space number differs does not hit. Entries of other address spaces stay resident and hit again when their number returns.
- R5: A write (`req_write`=1) that matches an entry loaded with `fill_wr_ok`=0 gives `rsp_fault`=1, `rsp_hit`=0, `rsp_miss`=0 and `rsp_pa`=0. A read of the same page hits.
- R6: A hit sets the entry's reference bit, and a hit by a permitted write sets its modify bit. `rsp_dirty_set`=1 exactly on the permitted write hit that finds the modify bit clear. Later write hits and all read hits give 0. Each entry has its own modify bit.
- R7: A fill is installed at the clock edge that accepts it. A request issued in the very next cycle hits it.
- R8: A fill goes to the lowest-numbered invalid entry while any entry is invalid, so no valid entry is replaced before all entries are valid.
- R9: When all entries are valid, the victim is chosen by a binary tree pseudo-LRU. Each fill or hit points every tree node on its path away from the used entry. After fills into entries 0..N-1 in order with no hits, the next fill replaces entry 0 and the one after it replaces entry N/2.
- R10: `flush_all` clears all valid bits in one cycle and takes priority over a fill in the same cycle. A request in a later cycle misses.
- R11: A cycle without a request gives `rsp_valid`=0 with all flags 0 and `rsp_pa`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_va | input | 32 | Virtual address |
| req_asn | input | 8 | Current address-space number |
| req_write | input | 1 | 1 = write access, 0 = read |
| flush_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_asn | input | 8 | Address-space number of the new entry |
| fill_ppn | input | 18 | Physical page number of the new entry |
| fill_wr_ok | input | 1 | Write permission of the new entry |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_pa | output | 30 | Physical address (0 unless hit) |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No entry matched; refill requested |
| rsp_fault | output | 1 | Write to a page without write permission |
| rsp_dirty_set | output | 1 | First permitted write to a clean page |

## Verification
The lookup path is driven with the same page under two address-space numbers and under an unused number. This separates a compare on the page alone from a compare on page and space together. Reads and writes to a read-only page show that the fault depends on the access type and not on presence. Repeated writes to one page, and to the same page in another space, show that the modify bit is kept per entry. Filling every entry in order and then adding two more pins down both the free-entry-first rule and the tree choice: exactly entry 0 and then the middle entry must disappear while all others still hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = 18;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int ASN_W = 8;

    typedef logic [VA_W-1:0]  va_t;
    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [PA_W-1:0]  pa_t;
    typedef logic [ASN_W-1:0] asn_t;
    typedef logic [OFF_W-1:0] off_t;

    // Part of an entry that takes part in the associative compare
    typedef struct packed {
        logic vld;
        vpn_t vpn;
        asn_t asn;
    } tlb_tag_t;

    // Full cached translation
    typedef struct packed {
        tlb_tag_t tag;
        ppn_t     ppn;
        logic     wr_ok;
        logic     refd;
        logic     dirty;
    } tlb_ent_t;

    // Registered lookup outcome
    typedef struct packed {
        logic vld;
        logic hit;
        logic miss;
        logic fault;
        logic dirty_set;
        pa_t  pa;
    } tlb_rsp_t;

    function automatic pa_t join_pa(ppn_t page, off_t off);
        return {page, off};
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 32
) (
    input  tlb_tag_t               tags [N],
    input  vpn_t                   vpn,
    input  asn_t                   asn,
    output logic                   hit,
    output logic [$clog2(N)-1:0]   idx
);

    localparam int IDX_W = $clog2(N);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = tags[g].vld && (tags[g].vpn == vpn) && (tags[g].asn == asn);
    end

    // Lowest matching index wins; duplicates are not expected
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         vld,
    input  logic                 touch_en,
    input  logic [$clog2(N)-1:0] touch_idx,
    output logic [$clog2(N)-1:0] victim
);

    localparam int LVL = $clog2(N);

    // Heap-ordered tree: node k has children 2k and 2k+1, bit 0 unused.
    // A node bit names the side to evict next (0 = lower half).
    logic [N-1:0]   tree_q, tree_d;
    logic [LVL-1:0] tree_vict, free_idx;
    logic           any_free;

    always_comb begin
        logic [LVL:0] node;
        node = (LVL+1)'(1);
        for (int l = 0; l < LVL; l++) begin
            node = {node[LVL-1:0], tree_q[node[LVL-1:0]]};
        end
        tree_vict = node[LVL-1:0];
    end

    always_comb begin
        any_free = ~&vld;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = LVL'(i);
        end
    end

    assign victim = any_free ? free_idx : tree_vict;

    always_comb begin
        logic [LVL:0]   node;
        logic [LVL-1:0] path;
        logic           side;
        tree_d = tree_q;
        node   = (LVL+1)'(1);
        path   = touch_idx;
        for (int l = 0; l < LVL; l++) begin
            side = path[LVL-1];
            if (touch_en) tree_d[node[LVL-1:0]] = ~side;
            node = {node[LVL-1:0], side};
            path = path << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tree_q <= '0;
        else     tree_q <= tree_d;
    end

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [ASN_W-1:0]   req_asn,
    input  logic               req_write,
    input  logic               flush_all,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [ASN_W-1:0]   fill_asn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic               fill_wr_ok,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_fault,
    output logic               rsp_dirty_set
);

    localparam int IDX_W = $clog2(N);

    tlb_ent_t        ents [N];
    tlb_tag_t        tags [N];
    logic [N-1:0]    ent_vld, ent_ref, ent_dirty;

    for (genvar g = 0; g < N; g++) begin : g_view
        assign tags[g]      = ents[g].tag;
        assign ent_vld[g]   = ents[g].tag.vld;
        assign ent_ref[g]   = ents[g].refd;
        assign ent_dirty[g] = ents[g].dirty;
    end

    // Lookup
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    vpn_t             req_vpn;
    off_t             req_off;

    assign req_vpn = req_va[VA_W-1:OFF_W];
    assign req_off = req_va[OFF_W-1:0];

    tlb_cam #(.N(N)) u_cam (
        .tags (tags),
        .vpn  (req_vpn),
        .asn  (req_asn),
        .hit  (lk_hit),
        .idx  (lk_idx)
    );

    logic fault_c, hit_c, miss_c, dset_c;

    always_comb begin
        fault_c = req_valid && lk_hit && req_write && !ents[lk_idx].wr_ok;
        hit_c   = req_valid && lk_hit && !fault_c;
        miss_c  = req_valid && !lk_hit;
        dset_c  = hit_c && req_write && !ents[lk_idx].dirty;
    end

    // Replacement
    logic [IDX_W-1:0] vict_idx, touch_idx;
    logic             touch_en;

    assign touch_en  = !flush_all && (fill_valid || hit_c);
    assign touch_idx = fill_valid ? vict_idx : lk_idx;

    tlb_repl #(.N(N)) u_repl (
        .clk       (clk),
        .rst       (rst),
        .vld       (ent_vld),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (vict_idx)
    );

    // Entry storage
    tlb_ent_t new_ent;

    always_comb begin
        new_ent           = '0;
        new_ent.tag.vld   = 1'b1;
        new_ent.tag.vpn   = fill_vpn;
        new_ent.tag.asn   = fill_asn;
        new_ent.ppn       = fill_ppn;
        new_ent.wr_ok     = fill_wr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ents[i] <= '0;
        end else if (flush_all) begin
            for (int i = 0; i < N; i++) ents[i].tag.vld <= 1'b0;
        end else begin
            if (hit_c) begin
                ents[lk_idx].refd <= 1'b1;
                if (req_write) ents[lk_idx].dirty <= 1'b1;
            end
            if (fill_valid) ents[vict_idx] <= new_ent;
        end
    end

    // Registered response
    tlb_rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d           = '0;
        rsp_d.vld       = req_valid;
        rsp_d.hit       = hit_c;
        rsp_d.miss      = miss_c;
        rsp_d.fault     = fault_c;
        rsp_d.dirty_set = dset_c;
        rsp_d.pa        = hit_c ? join_pa(ents[lk_idx].ppn, req_off) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.vld;
    assign rsp_pa        = rsp_q.pa;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_miss      = rsp_q.miss;
    assign rsp_fault     = rsp_q.fault;
    assign rsp_dirty_set = rsp_q.dirty_set;

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
    parameter int N = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 flush_all,
    input logic                 fill_valid,
    input logic                 lk_hit,
    input logic [$clog2(N)-1:0] lk_idx,
    input logic [$clog2(N)-1:0] vict_idx,
    input logic [N-1:0]         ent_vld,
    input logic [N-1:0]         ent_ref,
    input logic [N-1:0]         ent_dirty,
    input logic                 rsp_valid,
    input logic [29:0]          rsp_pa,
    input logic                 rsp_hit,
    input logic                 rsp_miss,
    input logic                 rsp_fault,
    input logic                 rsp_dirty_set
);

    logic upd_ok;
    assign upd_ok = !flush_all && !(fill_valid && vict_idx == lk_idx);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);  // R2

    AST_MISS_NO_PA: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> rsp_pa == '0);  // R3

    AST_FAULT_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> ($past(req_write) && rsp_pa == '0));  // R5

    AST_REF_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && $past(upd_ok)) |-> ent_ref[$past(lk_idx)]);  // R6

    AST_MOD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && $past(req_write) && $past(upd_ok)) |-> ent_dirty[$past(lk_idx)]);  // R6

    AST_DSET_WRITE_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_dirty_set |-> (rsp_hit && $past(req_write)));  // R6

    AST_FILL_INSTALLED: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !flush_all) |=> ent_vld[$past(vict_idx)]);  // R7

    AST_FILL_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !flush_all && !(&ent_vld)) |-> !ent_vld[vict_idx]);  // R8

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> ent_vld == '0);  // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && !rsp_dirty_set && rsp_pa == '0));  // R11

    AST_LOOKUP_KNOWN: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !$isunknown(lk_hit));  // R2

endmodule

bind tlb_assoc tlb_assoc_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .flush_all     (flush_all),
    .fill_valid    (fill_valid),
    .lk_hit        (lk_hit),
    .lk_idx        (lk_idx),
    .vict_idx      (vict_idx),
    .ent_vld       (ent_vld),
    .ent_ref       (ent_ref),
    .ent_dirty     (ent_dirty),
    .rsp_valid     (rsp_valid),
    .rsp_pa        (rsp_pa),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_fault     (rsp_fault),
    .rsp_dirty_set (rsp_dirty_set)
);

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;

    localparam int ENT = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, flush_all, fill_valid, fill_wr_ok;
    logic [31:0] req_va;
    logic [7:0]  req_asn, fill_asn;
    logic [19:0] fill_vpn;
    logic [17:0] fill_ppn;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_set;
    logic [29:0] rsp_pa;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tlb_assoc #(.N(ENT)) u_tlb_assoc (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_va (req_va), .req_asn (req_asn), .req_write (req_write),
        .flush_all (flush_all),
        .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_asn (fill_asn),
        .fill_ppn (fill_ppn), .fill_wr_ok (fill_wr_ok),
        .rsp_valid (rsp_valid), .rsp_pa (rsp_pa), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss),
        .rsp_fault (rsp_fault), .rsp_dirty_set (rsp_dirty_set)
    );

    // kind 0 = fill (page taken from va[31:12]), 1 = lookup
    // res  0 = hit, 1 = miss, 2 = fault
    typedef struct packed {
        logic        kind;
        logic [31:0] va;
        logic [7:0]  asn;
        logic        wr;
        logic [17:0] ppn;
        logic        wok;
        logic [1:0]  res;
        logic        dset;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b0, 32'h1234_5000, 8'd3, 1'b0, 18'h2ABCD, 1'b1, 2'd0, 1'b0, 4'd7},
        '{1'b0, 32'h0000_1000, 8'd3, 1'b0, 18'h00777, 1'b0, 2'd0, 1'b0, 4'd7},
        '{1'b0, 32'h1234_5000, 8'd5, 1'b0, 18'h11111, 1'b1, 2'd0, 1'b0, 4'd7},
        '{1'b1, 32'h1234_5678, 8'd3, 1'b0, 18'h2ABCD, 1'b0, 2'd0, 1'b0, 4'd2},  // R2
        '{1'b1, 32'h1234_5FFF, 8'd5, 1'b0, 18'h11111, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
        '{1'b1, 32'h1234_5000, 8'd7, 1'b0, 18'h00000, 1'b0, 2'd1, 1'b0, 4'd4},  // R4
        '{1'b1, 32'h5432_1000, 8'd3, 1'b0, 18'h00000, 1'b0, 2'd1, 1'b0, 4'd3},  // R3
        '{1'b1, 32'h0000_1ABC, 8'd3, 1'b1, 18'h00000, 1'b0, 2'd2, 1'b0, 4'd5},  // R5
        '{1'b1, 32'h0000_1ABC, 8'd3, 1'b0, 18'h00777, 1'b0, 2'd0, 1'b0, 4'd5},  // R5
        '{1'b1, 32'h1234_5010, 8'd3, 1'b1, 18'h2ABCD, 1'b0, 2'd0, 1'b1, 4'd6},  // R6
        '{1'b1, 32'h1234_5020, 8'd3, 1'b1, 18'h2ABCD, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
        '{1'b1, 32'h1234_5020, 8'd5, 1'b1, 18'h11111, 1'b0, 2'd0, 1'b1, 4'd6},  // R6
        '{1'b1, 32'h1234_5020, 8'd3, 1'b0, 18'h2ABCD, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
        '{1'b1, 32'h1234_5678, 8'd3, 1'b0, 18'h2ABCD, 1'b0, 2'd0, 1'b0, 4'd4}   // R4
    };

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [7:0] asn,
                           input logic [17:0] ppn, input logic wok);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asn = asn; fill_ppn = ppn; fill_wr_ok = wok;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_look(input logic [31:0] va, input logic [7:0] asn, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_asn = asn; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic eh, input logic em, input logic ef,
                       input logic ed, input logic [29:0] epa);
        checks++;
        if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_set, rsp_pa} !==
            {1'b1, eh, em, ef, ed, epa}) begin
            errors++;
            $display("FAIL %s: got v=%b h=%b m=%b f=%b d=%b pa=%h, exp v=1 h=%b m=%b f=%b d=%b pa=%h",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_set, rsp_pa,
                     eh, em, ef, ed, epa);
        end
    endtask

    task automatic chk_quiet(input string tag);
        checks++;
        if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_set, rsp_pa} !== '0) begin
            errors++;
            $display("FAIL %s: got v=%b h=%b m=%b f=%b d=%b pa=%h, exp all zero",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_set, rsp_pa);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_va = '0; req_asn = '0; req_write = 1'b0;
        flush_all = 1'b0; fill_valid = 1'b0; fill_vpn = '0; fill_asn = '0;
        fill_ppn = '0; fill_wr_ok = 1'b0;
        do_reset();

        // R1: quiet after reset, first lookup misses
        @(negedge clk);
        chk_quiet("R1 reset outputs");
        do_look(32'h1234_5678, 8'd3, 1'b0);
        chk("R1 empty lookup", 1'b0, 1'b1, 1'b0, 1'b0, '0);

        // Vector table
        for (int i = 0; i < 14; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.kind == 1'b0) begin
                do_fill(v.va[31:12], v.asn, v.ppn, v.wok);
            end else begin
                do_look(v.va, v.asn, v.wr);
                chk($sformatf("R%0d vector %0d", v.req, i),
                    v.res == 2'd0, v.res == 2'd1, v.res == 2'd2, v.dset,
                    (v.res == 2'd0) ? {v.ppn, v.va[11:0]} : 30'h0);
            end
        end

        // R11: no request gives a quiet response
        @(negedge clk);
        chk_quiet("R11 idle cycle");

        // R7: lookup in the cycle right after the fill
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h54321; fill_asn = 8'd3;
        fill_ppn = 18'h3FFFF; fill_wr_ok = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid = 1'b1; req_va = 32'h5432_1001; req_asn = 8'd3; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 fill then immediate lookup", 1'b1, 1'b0, 1'b0, 1'b0, {18'h3FFFF, 12'h001});

        // R10: flush clears everything
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        do_look(32'h1234_5678, 8'd3, 1'b0);
        chk("R10 after flush asn3", 1'b0, 1'b1, 1'b0, 1'b0, '0);
        do_look(32'h1234_5678, 8'd5, 1'b0);
        chk("R10 after flush asn5", 1'b0, 1'b1, 1'b0, 1'b0, '0);

        // R8 / R9: fill every entry in order, then two more
        do_reset();
        for (int i = 0; i < ENT; i++) begin
            do_fill(20'h00100 + 20'(i), 8'd1, 18'(i), 1'b1);
        end
        do_fill(20'h00200, 8'd1, 18'h00200, 1'b1);
        do_fill(20'h00201, 8'd1, 18'h00201, 1'b1);

        do_look(32'h0010_0000, 8'd1, 1'b0);
        chk("R9 entry 0 replaced first", 1'b0, 1'b1, 1'b0, 1'b0, '0);
        do_look(32'h0010_0000 + 32'((ENT / 2) << 12), 8'd1, 1'b0);
        chk("R9 middle entry replaced second", 1'b0, 1'b1, 1'b0, 1'b0, '0);
        for (int i = 1; i < ENT; i++) begin
            if (i != ENT / 2) begin
                do_look(32'h0010_0000 + 32'(i << 12) + 32'h0AB, 8'd1, 1'b0);
                chk($sformatf("R8 entry %0d kept", i), 1'b1, 1'b0, 1'b0, 1'b0,
                    {18'(i), 12'h0AB});
            end
        end
        do_look(32'h0020_0123, 8'd1, 1'b0);
        chk("R9 first extra fill", 1'b1, 1'b0, 1'b0, 1'b0, {18'h00200, 12'h123});
        do_look(32'h0020_1456, 8'd1, 1'b0);
        chk("R9 second extra fill", 1'b1, 1'b0, 1'b0, 1'b0, {18'h00201, 12'h456});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule